// File: doc/BRIEF.md
# Calculator Key Sequencer

This block is the control half of a two-operand keypad calculator. It watches single-cycle key events that an upstream keypad classifier produces (a digit, an arithmetic operator, an equals request, a clear request and a power-on wake key). From them it drives the load strobes of the datapath registers, a register-clear line and the selector that picks which value the display shows.

The sequencer has five phases: idle, first operand entry, operator entry, second operand entry and result display. A key is acted on only when it makes sense in the current phase. Any other key is dropped without side effects. The wake key returns the machine to idle from any phase and clears the datapath. Once a result is on display, only the clear key leaves that phase.

Load strobes and the clear line are decoded in the same cycle as the accepted key, so the datapath captures the key value that is present alongside the event. The display selector depends only on the phase.

Top module: `calc_seq_ctrl`

## Requirements
- R1: An asynchronous low `rst_n`, or a `key_wake` pulse, puts the machine in idle. During a `key_wake` cycle `clr_regs` is 1 and no load strobe fires, whatever other keys are present.
- R2: In idle, a digit key raises `load_first` in that cycle and moves the machine to first operand entry.
- R3: In first operand entry, a digit raises `load_first` and the machine stays. An operator key raises `load_oper` and moves to operator entry. The operator wins when both keys arrive in the same cycle.
- R4: In operator entry, a digit raises `load_second` and moves the machine to second operand entry.
- R5: In second operand entry, a digit raises `load_second` and the machine stays. The equals key raises `load_result` and moves to result display. Equals wins over a digit in the same cycle.
- R6: In result display, the clear key raises `clr_regs` for that cycle and returns the machine to idle. No other key leaves result display.
- R7: Keys that do not fit the phase cause no strobe, no clear and no phase change. These are operator, equals and clear in idle. They are equals and clear in first operand entry, and operator, equals and clear in operator entry. They are operator and clear in second operand entry, and digit, operator and equals in result display.
- R8: `show_sel` is 2'b00 in idle, first operand entry and operator entry. It is 2'b01 in second operand entry and 2'b10 in result display. It is never 2'b11.
- R9: Load strobes are combinational with the accepted key (same cycle), and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_digit | input | 1 | Digit key pulse |
| key_oper | input | 1 | Operator key pulse |
| key_equal | input | 1 | Equals key pulse |
| key_clear | input | 1 | Clear key pulse |
| key_wake | input | 1 | Power-on/wake key pulse, global reset |
| load_first | output | 1 | Shift a digit into the first operand register |
| load_second | output | 1 | Shift a digit into the second operand register |
| load_oper | output | 1 | Capture the operator code |
| load_result | output | 1 | Capture the arithmetic result |
| clr_regs | output | 1 | Zero all datapath registers |
| show_sel | output | 2 | Display source: 00 first operand, 01 second operand, 10 result |

## Verification
A wrong phase register shows at the ports in one of two ways. It shows at once through `show_sel`, if the wrong phase has a different display code. Otherwise it shows on the next key, which raises the wrong strobe or none. Phases that share the 00 display code (idle, first operand and operator entry) can only be told apart by sending keys. The bench therefore follows every phase change with digits, operators and ignored keys, so that a mixed-up phase appears within one key event. Keys pressed together and the wake key in every phase are driven, to pin down the priority rules.

// File: rtl/calc_seq_pkg.sv
package calc_seq_pkg;
  localparam int SEL_W   = 2;
  localparam int PHASE_W = 3;
  localparam int LOAD_N  = 4;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE  = 3'd0,
    PH_OPND1 = 3'd1,
    PH_OPER  = 3'd2,
    PH_OPND2 = 3'd3,
    PH_SHOW  = 3'd4
  } phase_t;

  typedef struct packed {
    logic first;
    logic second;
    logic oper;
    logic result;
    logic clear;
    logic wake;
  } take_t;

  localparam logic [SEL_W-1:0] SEL_OPND1  = 2'b00;
  localparam logic [SEL_W-1:0] SEL_OPND2  = 2'b01;
  localparam logic [SEL_W-1:0] SEL_RESULT = 2'b10;

  function automatic logic [SEL_W-1:0] sel_of(input phase_t p);
    case (p)
      PH_OPND2: sel_of = SEL_OPND2;
      PH_SHOW:  sel_of = SEL_RESULT;
      default:  sel_of = SEL_OPND1;
    endcase
  endfunction

  function automatic phase_t phase_after(input phase_t p, input take_t t);
    if (t.wake)        phase_after = PH_IDLE;
    else if (t.clear)  phase_after = PH_IDLE;
    else if (t.result) phase_after = PH_SHOW;
    else if (t.oper)   phase_after = PH_OPER;
    else if (t.second) phase_after = PH_OPND2;
    else if (t.first)  phase_after = PH_OPND1;
    else               phase_after = p;
  endfunction
endpackage

// File: rtl/calc_seq_accept.sv
module calc_seq_accept
  import calc_seq_pkg::*;
(
  input  phase_t phase,
  input  logic   key_digit,
  input  logic   key_oper,
  input  logic   key_equal,
  input  logic   key_clear,
  input  logic   key_wake,
  output take_t  take
);
  logic live;
  assign live = ~key_wake;

  always_comb begin
    take        = '0;
    take.wake   = key_wake;
    take.first  = live & key_digit &
                  ((phase == PH_IDLE) | ((phase == PH_OPND1) & ~key_oper));
    take.oper   = live & key_oper & (phase == PH_OPND1);
    take.second = live & key_digit &
                  ((phase == PH_OPER) | ((phase == PH_OPND2) & ~key_equal));
    take.result = live & key_equal & (phase == PH_OPND2);
    take.clear  = live & key_clear & (phase == PH_SHOW);
  end
endmodule

// File: rtl/calc_seq_state.sv
module calc_seq_state
  import calc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  take_t  take,
  output phase_t phase
);
  phase_t phase_nxt;
  assign phase_nxt = phase_after(phase, take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end
endmodule

// File: rtl/calc_seq_drive.sv
module calc_seq_drive
  import calc_seq_pkg::*;
(
  input  phase_t            phase,
  input  take_t             take,
  output logic [LOAD_N-1:0] loads,
  output logic              clr,
  output logic [SEL_W-1:0]  sel
);
  assign loads = {take.first, take.second, take.oper, take.result};
  assign clr   = take.wake | take.clear;
  assign sel   = sel_of(phase);
endmodule

// File: rtl/calc_seq_ctrl.sv
module calc_seq_ctrl
  import calc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_digit,
  input  logic             key_oper,
  input  logic             key_equal,
  input  logic             key_clear,
  input  logic             key_wake,
  output logic             load_first,
  output logic             load_second,
  output logic             load_oper,
  output logic             load_result,
  output logic             clr_regs,
  output logic [SEL_W-1:0] show_sel
);
  phase_t            phase;
  take_t             take;
  logic [LOAD_N-1:0] loads;

  calc_seq_accept u_accept (
    .phase(phase), .key_digit(key_digit), .key_oper(key_oper),
    .key_equal(key_equal), .key_clear(key_clear), .key_wake(key_wake),
    .take(take)
  );

  calc_seq_state u_state (
    .clk(clk), .rst_n(rst_n), .take(take), .phase(phase)
  );

  calc_seq_drive u_drive (
    .phase(phase), .take(take), .loads(loads), .clr(clr_regs), .sel(show_sel)
  );

  assign {load_first, load_second, load_oper, load_result} = loads;
endmodule

// File: rtl/calc_seq_chk.sv
module calc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       key_clear,
  input logic       key_wake,
  input logic       load_first,
  input logic       load_second,
  input logic       load_oper,
  input logic       load_result,
  input logic       clr_regs,
  input logic [1:0] show_sel
);
  logic any_load;
  assign any_load = load_first | load_second | load_oper | load_result;

  assert_one_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_first, load_second, load_oper, load_result}));

  assert_sel_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    show_sel != 2'b11);

  assert_wake_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    key_wake |-> (clr_regs && !any_load));

  assert_wake_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    key_wake |=> show_sel == 2'b00);

  assert_second_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_second && !key_wake) |=> show_sel == 2'b01);

  assert_result_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_result && !key_wake) |=> show_sel == 2'b10);

  assert_show_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (show_sel == 2'b10 && !key_clear && !key_wake) |=> show_sel == 2'b10);

  assert_show_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (show_sel == 2'b10 && key_clear) |-> clr_regs);

  assert_show_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (show_sel == 2'b10) |-> !any_load);
endmodule

bind calc_seq_ctrl calc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .key_clear(key_clear), .key_wake(key_wake),
  .load_first(load_first), .load_second(load_second), .load_oper(load_oper),
  .load_result(load_result), .clr_regs(clr_regs), .show_sel(show_sel)
);

// File: tb/calc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module calc_seq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic k_dig = 0, k_op = 0, k_eq = 0, k_clr = 0, k_wake = 0;
  logic ld_a, ld_b, ld_o, ld_r, clr;
  logic [1:0] sel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  calc_seq_ctrl u_calc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .key_digit(k_dig), .key_oper(k_op),
    .key_equal(k_eq), .key_clear(k_clr), .key_wake(k_wake),
    .load_first(ld_a), .load_second(ld_b), .load_oper(ld_o),
    .load_result(ld_r), .clr_regs(clr), .show_sel(sel)
  );

  typedef struct packed {
    logic [3:0] loads;
    logic       clr;
    logic [1:0] sel;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    m_ph = 0;

  function automatic logic [1:0] disp_code(input int ph);
    if (ph == 4) return 2'b10;
    if (ph == 3) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // driver: one key pattern per cycle, expectation pushed to the scoreboard
  task automatic send(input logic d, input logic o, input logic e,
                      input logic c, input logic w, input string tag);
    exp_t x;
    x = '0;
    @(negedge clk);
    k_dig = d; k_op = o; k_eq = e; k_clr = c; k_wake = w;
    if (w) begin
      x.clr = 1'b1; m_ph = 0;
    end else begin
      case (m_ph)
        0: if (d) begin x.loads = 4'b1000; m_ph = 1; end
        1: if (o) begin x.loads = 4'b0010; m_ph = 2; end
           else if (d) x.loads = 4'b1000;
        2: if (d) begin x.loads = 4'b0100; m_ph = 3; end
        3: if (e) begin x.loads = 4'b0001; m_ph = 4; end
           else if (d) x.loads = 4'b0100;
        default: if (c) begin x.clr = 1'b1; m_ph = 0; end
      endcase
    end
    x.sel = disp_code(m_ph);
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  // monitor: strobes before the edge, display after it
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (exp_q.size() > 0) begin
        exp_t  x;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "loads", {4'b0, ld_a, ld_b, ld_o, ld_r}, {4'b0, x.loads});
        check(t, "clr", {7'b0, clr}, {7'b0, x.clr});
        @(posedge clk);
        #1;
        check(t, "show_sel", {6'b0, sel}, {6'b0, x.sel});
      end
    end
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset sel", {6'b0, sel}, 8'h00);
    check("R1", "reset loads", {3'b0, ld_a, ld_b, ld_o, ld_r, clr}, 8'h00);
    rst_n = 1'b1;
    // idle: ignored keys then first digit
    send(0,1,0,0,0,"R7"); send(0,0,1,0,0,"R7"); send(0,0,0,1,0,"R7");
    send(0,0,0,0,0,"R2"); send(1,0,0,0,0,"R2");
    // first operand
    send(1,0,0,0,0,"R3"); send(1,0,0,0,0,"R3");
    send(0,0,1,0,0,"R7"); send(0,0,0,1,0,"R7");
    send(1,1,0,0,0,"R3");
    // operator entry
    send(0,1,0,0,0,"R7"); send(0,0,1,0,0,"R7"); send(0,0,0,1,0,"R7");
    send(1,0,0,0,0,"R4");
    // second operand
    send(1,0,0,0,0,"R5"); send(0,1,0,0,0,"R7"); send(0,0,0,1,0,"R7");
    send(1,0,1,0,0,"R5");
    // result display
    send(1,0,0,0,0,"R7"); send(0,1,0,0,0,"R7"); send(0,0,1,0,0,"R7");
    send(0,0,0,0,0,"R8"); send(0,0,0,1,0,"R6");
    // wake from each phase and with other keys
    send(1,0,0,0,0,"R2"); send(0,1,0,0,0,"R3"); send(1,0,0,0,0,"R4");
    send(1,1,1,1,1,"R1"); send(1,0,0,0,1,"R1");
    send(1,0,0,0,0,"R2"); send(0,1,0,0,0,"R3"); send(1,0,0,0,0,"R4");
    send(0,0,1,0,0,"R5"); send(0,0,0,1,1,"R1");
    send(1,0,0,0,0,"R2"); send(0,0,0,0,1,"R1");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 31);
      send(r[0], r[1], r[2], r[3], (r[4] && (i % 7 == 0)), "R9");
    end
    send(0,0,0,0,0,"R8");
    k_dig = 0; k_op = 0; k_eq = 0; k_clr = 0; k_wake = 0;
    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule